// File: doc/BRIEF.md
# Channel Scan Sequencer

This block decides which multiplexer input a converter samples on each acquisition. On every conversion strobe it registers a new selection: one input channel, an adjacent pair of channels, or the on-die temperature sensor. In scan mode it walks upward from input 0 to a programmable last channel. It can then insert one temperature-sensor slot before it returns to input 0. In fixed mode it keeps selecting one programmed channel.

A configuration word is written at any time. The word is first held in a staging register and becomes active on the next strobe. The selection made at that same strobe still follows the old setting. From the strobe after it, the new setting is used, and the scan starts again at input 0. The block therefore behaves like a converter that is always one frame behind its configuration port. The analog switches are driven from `mux_sel`, `pair_sel` and `temp_sel` and are not part of this block.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset, mux_sel is 0 and temp_sel and pair_sel are 0. The active setting is a single-input scan of all channels with the temperature slot enabled, and no write is pending.
- R2: The outputs change only at the clock edge where conv_go is high. They hold their value on every other cycle.
- R3: In scan mode with pairing off, successive strobes select 0, 1, 2 and so on up to the last-channel field, each with pair_sel 0. After the last channel the scan returns to 0.
- R4: When the temperature-enable bit is set in scan mode, the strobe after the last channel or last pair asserts temp_sel with mux_sel 0 and pair_sel 0. The strobe after that selects input 0 again.
- R5: In scan mode with pairing on, strobes select even channels 0, 2, 4 and so on with pair_sel 1, meaning mux_sel and mux_sel+1 together. The last pair is the one that contains the last-channel value.
- R6: With the scan-enable bit clear, every strobe sets mux_sel to the fixed-channel field and sets temp_sel and pair_sel to 0. The pairing and temperature bits have no effect in this mode.
- R7: A word written before strobe k becomes active at strobe k. The selection registered at strobe k still follows the previous setting, and selections from strobe k+1 onward follow the new word.
- R8: Every committed write restarts the scan, so the first scan-mode selection under the new word is input 0.
- R9: A write in the same cycle as a strobe is staged after that strobe's commit and becomes active at the next strobe. Of several writes before one strobe, the last one wins.
- R10: The configuration word, for 8 channels, uses these bits: [2:0] fixed channel, [5:3] last channel, [6] temperature enable, [7] pairing, [8] scan enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_go | input | 1 | One-cycle conversion strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 2*log2(NUM_CH)+3 | Configuration word (layout in R10) |
| mux_sel | output | log2(NUM_CH) | Selected channel, or the lower channel of a pair |
| temp_sel | output | 1 | Temperature sensor selected |
| pair_sel | output | 1 | Channels mux_sel and mux_sel+1 selected as a pair |

## Verification
Each wrong internal state shows up at the outputs at a known strobe. A stale or skipped scan index gives a wrong mux_sel at the next strobe. A missed end-of-scan compare appears at the strobe where the temperature slot or the wrap should happen. A staging fault, such as committing a write too early, too late or not at all, shifts the scan order by exactly one strobe. The check that follows every write therefore looks at the first two strobes after it. A pairing fault appears as an odd mux_sel or a wrong pair boundary at the top of the scan.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    typedef enum logic {
        PH_CHAN = 1'b0,
        PH_TEMP = 1'b1
    } seqr_phase_e;

    // Field offsets of the configuration word for a channel index width chw
    function automatic int unsigned seqr_last_lo(input int unsigned chw);
        return chw;
    endfunction

    function automatic int unsigned seqr_temp_bit(input int unsigned chw);
        return 2 * chw;
    endfunction

    function automatic int unsigned seqr_pair_bit(input int unsigned chw);
        return 2 * chw + 1;
    endfunction

    function automatic int unsigned seqr_scan_bit(input int unsigned chw);
        return 2 * chw + 2;
    endfunction

    function automatic int unsigned seqr_cfg_width(input int unsigned chw);
        return 2 * chw + 3;
    endfunction

endpackage

// File: rtl/seqr_cfg_stage.sv
module seqr_cfg_stage #(
    parameter int unsigned CFG_W = 9,
    parameter logic [CFG_W-1:0] RST_WORD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_word,
    input  logic             conv_go,
    output logic [CFG_W-1:0] act_word,
    output logic             commit
);

    typedef struct packed {
        logic [CFG_W-1:0] stg;
        logic             pend;
        logic [CFG_W-1:0] act;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        commit = conv_go && s_q.pend;
        if (commit) begin
            s_d.act  = s_q.stg;
            s_d.pend = 1'b0;
        end
        // a write in the strobe cycle lands after the commit
        if (wr_en) begin
            s_d.stg  = wr_word;
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stg  <= RST_WORD;
            s_q.pend <= 1'b0;
            s_q.act  <= RST_WORD;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_word = s_q.act;

    // R7: a commit loads the staged word
    p_commit_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_go && s_q.pend) |=> (act_word == $past(s_q.stg)));

    // R7: without a commit the active word does not move
    p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_go && s_q.pend) |=> $stable(act_word));

    // R9: a write always leaves a pending word
    p_write_pends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.pend && s_q.stg == $past(wr_word)));

endmodule

// File: rtl/seqr_scan_core.sv
module seqr_scan_core
    import seqr_pkg::*;
#(
    parameter int unsigned CH_W  = 3,
    parameter int unsigned CFG_W = seqr_cfg_width(CH_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_go,
    input  logic             restart,
    input  logic [CFG_W-1:0] act_word,
    output logic [CH_W-1:0]  emit_ch,
    output logic             emit_temp,
    output logic             emit_pair
);

    localparam int unsigned LAST_LO  = seqr_last_lo(CH_W);
    localparam int unsigned TEMP_BIT = seqr_temp_bit(CH_W);
    localparam int unsigned PAIR_BIT = seqr_pair_bit(CH_W);
    localparam int unsigned SCAN_BIT = seqr_scan_bit(CH_W);

    typedef struct packed {
        logic [CH_W-1:0] idx;
        seqr_phase_e     phase;
    } scan_t;

    scan_t c_d, c_q;

    logic [CH_W-1:0] fixed_ch;
    logic [CH_W-1:0] last_ch;
    logic            temp_en;
    logic            pair_en;
    logic            scan_en;
    logic [CH_W-1:0] end_idx;
    logic [CH_W-1:0] step;
    logic            at_end;

    always_comb begin
        fixed_ch = act_word[CH_W-1:0];
        last_ch  = act_word[LAST_LO +: CH_W];
        temp_en  = act_word[TEMP_BIT];
        pair_en  = act_word[PAIR_BIT];
        scan_en  = act_word[SCAN_BIT];
    end

    // the closing pair is the even/odd couple holding the last channel
    generate
        if (CH_W > 1) begin : g_pair_end
            always_comb begin
                end_idx = pair_en ? {last_ch[CH_W-1:1], 1'b0} : last_ch;
                step    = pair_en ? CH_W'(2) : CH_W'(1);
            end
        end else begin : g_pair_end_narrow
            always_comb begin
                end_idx = pair_en ? '0 : last_ch;
                step    = pair_en ? '0 : CH_W'(1);
            end
        end
    endgenerate

    always_comb begin
        at_end = (c_q.idx == end_idx);

        // selection emitted at this strobe
        if (!scan_en) begin
            emit_ch   = fixed_ch;
            emit_temp = 1'b0;
            emit_pair = 1'b0;
        end else if (c_q.phase == PH_TEMP) begin
            emit_ch   = '0;
            emit_temp = 1'b1;
            emit_pair = 1'b0;
        end else begin
            emit_ch   = c_q.idx;
            emit_temp = 1'b0;
            emit_pair = pair_en;
        end

        // position for the strobe after this one
        c_d = c_q;
        if (conv_go && scan_en) begin
            if (c_q.phase == PH_TEMP) begin
                c_d.idx   = '0;
                c_d.phase = PH_CHAN;
            end else if (at_end) begin
                if (temp_en) begin
                    c_d.phase = PH_TEMP;
                end else begin
                    c_d.idx = '0;
                end
            end else begin
                c_d.idx = c_q.idx + step;
            end
        end
        if (restart) begin
            c_d.idx   = '0;
            c_d.phase = PH_CHAN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.idx   <= '0;
            c_q.phase <= PH_CHAN;
        end else begin
            c_q <= c_d;
        end
    end

    // R3: the index never runs past the last channel
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.idx <= last_ch);

    // R5: paired scans stay on even channels
    p_pair_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && pair_en) |-> (c_q.idx[0] == 1'b0));

    // R4: the temperature slot is followed by input 0
    p_temp_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_go && scan_en && c_q.phase == PH_TEMP) |=>
            (c_q.idx == '0 && c_q.phase == PH_CHAN));

    // R8: a commit restarts the scan
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (c_q.idx == '0 && c_q.phase == PH_CHAN));

endmodule

// File: rtl/seqr_sel_out.sv
module seqr_sel_out #(
    parameter int unsigned CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_go,
    input  logic [CH_W-1:0] emit_ch,
    input  logic            emit_temp,
    input  logic            emit_pair,
    output logic [CH_W-1:0] mux_sel,
    output logic            temp_sel,
    output logic            pair_sel
);

    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic            temp;
        logic            pair;
    } sel_t;

    sel_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (conv_go) begin
            o_d.ch   = emit_ch;
            o_d.temp = emit_temp;
            o_d.pair = emit_pair;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign mux_sel  = o_q.ch;
    assign temp_sel = o_q.temp;
    assign pair_sel = o_q.pair;

    // R2: outputs hold between strobes
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_go |=> $stable({mux_sel, temp_sel, pair_sel}));

    // R4: the temperature slot selects no input channel
    p_temp_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        temp_sel |-> (mux_sel == '0 && !pair_sel));

endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
    import seqr_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   conv_go,
    input  logic                                   cfg_wr,
    input  logic [seqr_cfg_width($clog2(NUM_CH))-1:0] cfg_word,
    output logic [$clog2(NUM_CH)-1:0]              mux_sel,
    output logic                                   temp_sel,
    output logic                                   pair_sel
);

    localparam int unsigned CH_W     = $clog2(NUM_CH);
    localparam int unsigned CFG_W    = seqr_cfg_width(CH_W);
    localparam int unsigned LAST_LO  = seqr_last_lo(CH_W);
    localparam int unsigned TEMP_BIT = seqr_temp_bit(CH_W);
    localparam int unsigned SCAN_BIT = seqr_scan_bit(CH_W);

    // power-up setting: full single-input scan plus the sensor slot
    localparam logic [CFG_W-1:0] RST_WORD =
        (CFG_W'(1) << SCAN_BIT) |
        (CFG_W'(1) << TEMP_BIT) |
        (CFG_W'(NUM_CH - 1) << LAST_LO);

    logic [CFG_W-1:0] act_word;
    logic             commit;
    logic [CH_W-1:0]  emit_ch;
    logic             emit_temp;
    logic             emit_pair;

    seqr_cfg_stage #(
        .CFG_W    (CFG_W),
        .RST_WORD (RST_WORD)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_word  (cfg_word),
        .conv_go  (conv_go),
        .act_word (act_word),
        .commit   (commit)
    );

    seqr_scan_core #(
        .CH_W  (CH_W),
        .CFG_W (CFG_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_go   (conv_go),
        .restart   (commit),
        .act_word  (act_word),
        .emit_ch   (emit_ch),
        .emit_temp (emit_temp),
        .emit_pair (emit_pair)
    );

    seqr_sel_out #(
        .CH_W (CH_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_go   (conv_go),
        .emit_ch   (emit_ch),
        .emit_temp (emit_temp),
        .emit_pair (emit_pair),
        .mux_sel   (mux_sel),
        .temp_sel  (temp_sel),
        .pair_sel  (pair_sel)
    );

    // R6: fixed mode follows the fixed-channel field
    p_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_go && !act_word[SCAN_BIT]) |=>
            (mux_sel == $past(act_word[CH_W-1:0]) && !temp_sel && !pair_sel));

endmodule

// File: tb/chan_scan_seq_test.sv
module chan_scan_seq_test;

    logic       clk;
    logic       rst_n;
    logic       conv_go;
    logic       cfg_wr;
    logic [8:0] cfg_word;
    logic [2:0] mux_sel;
    logic       temp_sel;
    logic       pair_sel;

    int total = 0;
    int bad   = 0;

    typedef struct packed {
        logic [2:0] ch;
        logic       t;
        logic       p;
    } sel_t;

    sel_t  exp_q[$];
    string tag_q[$];
    sel_t  last_exp;

    // bench model of the requirements
    logic [8:0] m_act;
    logic [8:0] m_stg;
    bit         m_pend;
    int         m_idx;
    bit         m_tmp;

    chan_scan_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_go  (conv_go),
        .cfg_wr   (cfg_wr),
        .cfg_word (cfg_word),
        .mux_sel  (mux_sel),
        .temp_sel (temp_sel),
        .pair_sel (pair_sel)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    task automatic chk(input string tag, input sel_t got, input sel_t want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got ch=%0d temp=%0b pair=%0b expected ch=%0d temp=%0b pair=%0b",
                     tag, got.ch, got.t, got.p, want.ch, want.t, want.p);
        end
    endtask

    // R10 field layout: [2:0] fixed, [5:3] last, [6] temp, [7] pair, [8] scan
    task automatic model_strobe(input bit w, input logic [8:0] wd, output sel_t e);
        bit scan  = m_act[8];
        bit pr    = m_act[7];
        bit te    = m_act[6];
        int last  = int'(m_act[5:3]);
        bit done;
        if (!scan) begin
            e = '{ch: m_act[2:0], t: 1'b0, p: 1'b0};
        end else if (m_tmp) begin
            e = '{ch: 3'd0, t: 1'b1, p: 1'b0};
            m_tmp = 1'b0;
            m_idx = 0;
        end else begin
            e = '{ch: 3'(m_idx), t: 1'b0, p: pr};
            done = pr ? ((m_idx / 2) == (last / 2)) : (m_idx == last);
            if (done) begin
                if (te) m_tmp = 1'b1;
                else    m_idx = 0;
            end else begin
                m_idx = m_idx + (pr ? 2 : 1);
            end
        end
        if (m_pend) begin
            m_act  = m_stg;
            m_pend = 1'b0;
            m_idx  = 0;
            m_tmp  = 1'b0;
        end
        if (w) begin
            m_stg  = wd;
            m_pend = 1'b1;
        end
    endtask

    // driver: called at a falling edge, returns at the next falling edge
    task automatic conv(input string tag, input bit w = 1'b0, input logic [8:0] wd = 9'h0);
        sel_t e;
        model_strobe(w, wd, e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        conv_go  = 1'b1;
        cfg_wr   = w;
        cfg_word = wd;
        @(negedge clk);
        conv_go = 1'b0;
        cfg_wr  = 1'b0;
    endtask

    task automatic wr_cfg(input logic [8:0] wd);
        m_stg    = wd;
        m_pend   = 1'b1;
        cfg_wr   = 1'b1;
        cfg_word = wd;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // monitor: pop and compare after each strobe edge
    initial begin
        forever begin
            @(posedge clk);
            if (conv_go === 1'b1) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL R2: got ch=%0d with no expected item, expected none", mux_sel);
                end else begin
                    chk(tag_q.pop_front(), '{ch: mux_sel, t: temp_sel, p: pair_sel}, exp_q.pop_front());
                end
            end
        end
    end

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        conv_go  = 1'b0;
        cfg_wr   = 1'b0;
        cfg_word = 9'h0;
        m_act    = 9'h178;
        m_stg    = 9'h178;
        m_pend   = 1'b0;
        m_idx    = 0;
        m_tmp    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset outputs
        chk("R1", '{ch: mux_sel, t: temp_sel, p: pair_sel}, '{ch: 3'd0, t: 1'b0, p: 1'b0});

        // R1, R3, R4: power-up scan 0..7, sensor, wrap
        for (int i = 0; i < 10; i++) conv("R1 R3 R4 default scan");

        // R2: outputs hold while idle
        repeat (5) @(negedge clk);
        chk("R2", '{ch: mux_sel, t: temp_sel, p: pair_sel}, last_exp);

        // R7, R8, R3: single scan to 3, no sensor (R10 word 0x118)
        wr_cfg(9'h118);
        conv("R7 old setting");
        for (int i = 0; i < 6; i++) conv("R3 R8 short scan");

        // R8: rewrite mid-scan restarts at input 0
        wr_cfg(9'h118);
        conv("R7 R8 commit strobe");
        conv("R8 restart");
        conv("R8 after restart");

        // R5, R4: pairs with last 5 plus sensor (0x1E8)
        wr_cfg(9'h1E8);
        for (int i = 0; i < 7; i++) conv("R5 R4 pair scan");

        // R5: pairs with last 6, no sensor (0x1B0)
        wr_cfg(9'h1B0);
        for (int i = 0; i < 7; i++) conv("R5 pair scan last 6");

        // R6: fixed channel 5 with pair and temp bits set (0x0FD)
        wr_cfg(9'h0FD);
        for (int i = 0; i < 4; i++) conv("R6 fixed channel");
        repeat (3) @(negedge clk);
        chk("R6 R2 hold", '{ch: mux_sel, t: temp_sel, p: pair_sel}, last_exp);

        // R9: write in the strobe cycle, single scan last 2 (0x110)
        conv("R9 write with strobe", 1'b1, 9'h110);
        for (int i = 0; i < 6; i++) conv("R9 R3 scan after late write");

        // R9: last of two writes wins (0x1F8 then 0x128)
        wr_cfg(9'h1F8);
        wr_cfg(9'h128);
        for (int i = 0; i < 8; i++) conv("R9 last write wins");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule